// File: doc/BRIEF.md
# Multichannel Charge Sum and Maximum Front End

This block sits at the first digital stage behind sixteen digitised photomultiplier channels. Every beat carries one 10-bit sample per channel, a per-channel hit flag and a per-channel 12-bit arrival time produced upstream. The block scales each sample by a per-channel fixed-point gain and removes a per-channel pedestal. From the sixteen corrected charges it forms the total, picks the channel with the largest charge, and finds the earliest arrival time among the channels that report a hit. The results go out as one 48-bit word per beat toward the next processing layer.

Alongside the arithmetic path, every accepted beat's raw samples are written into a circular history buffer. A plain read port returns any channel's sample from any of the most recent beats, so slower readout logic can recover waveforms after a decision.

Input and output use valid/ready. The whole pipeline advances together. A beat enters on a clock edge where `in_valid` and `in_ready` are both high. The output word is taken on an edge where `out_valid` and `out_ready` are both high. While the output holds a word that is not taken, the pipeline freezes and `in_ready` stays low. Gain and pedestal settings are static configuration and must not change while beats are in flight.

Top module: `pmt_sum_front`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_word` and `out_valid` hold their values on the next edge.
- R2: With `out_ready` held high, the result of a beat accepted on edge k is presented with `out_valid` high after edge k+5, which is the sixth edge counting edge k as the first. It is not presented earlier.
- R3: The corrected charge of channel c is max(0, floor(sample·gain/64) − pedestal). Here gain is the 8-bit unsigned value at `gain_cfg[8c+7:8c]`, with 6 fractional bits, and pedestal is the 12-bit value at `ped_cfg[12c+11:12c]`. The result is limited to 4095.
- R4: `out_word[47:32]` is the sum of the sixteen corrected charges.
- R5: `out_word[31:28]` is the index of the channel with the largest corrected charge, and `out_word[27:16]` is that charge. On a tie the lowest-numbered channel wins, so when all charges are zero the index is 0.
- R6: `out_word[3]` is high when any `in_hits` bit was set. `out_word[15:4]` is the smallest `in_times[12c+11:12c]` over channels with `in_hits[c]` set. Times of channels without a hit are ignored. With no hit the field reads 0xFFF.
- R7: `out_word[2:0]` are zero.
- R8: After reset, `out_valid` is low and `in_ready` is high.
- R9: One edge after `rd_ch` and `rd_age` are applied, `rd_data` holds the raw sample of channel `rd_ch` from the accepted beat `rd_age` beats before the most recent one (age 0 is the most recent). The 16 most recent beats are retained, and the oldest is overwritten first.
- R10: Under any pattern of `out_ready` stalls, every accepted beat yields exactly one output word, in order of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_samples | input | 160 | Raw samples, channel c at [10c+9:10c] |
| in_hits | input | 16 | Hit flag per channel |
| in_times | input | 192 | Arrival time, channel c at [12c+11:12c] |
| gain_cfg | input | 128 | Gain per channel, 8 bits, 6 fractional |
| ped_cfg | input | 192 | Pedestal per channel, 12 bits |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_word | output | 48 | Packed result word |
| rd_ch | input | 4 | History read channel |
| rd_age | input | 4 | History read age in beats |
| rd_data | output | 10 | History read sample |

## Verification
Uniform samples across all channels test tie-breaking. A ramp and a pair of equal peaks show whether the winner comes from the lowest index or from the last index compared. Pedestals above some scaled samples exercise the clamp at zero. Full-scale, zero and half gain settings separate correct fixed-point scaling and truncation from an off-by-one shift. Hit patterns where a channel without a hit carries the smallest time show whether the hit mask is applied, and a hit at time 0xFFF checks that the hit flag does not depend on the time value. Long runs of random beats under random `out_ready` stalls expose lost, duplicated or reordered words. Reads of the history buffer at ages up to 15, after more than sixteen beats, check wrap-around.

// File: rtl/pmt_sum_pkg.sv
package pmt_sum_pkg;
  localparam int Q_W    = 12;
  localparam int T_W    = 12;
  localparam int SUM_W  = 16;
  localparam int IDX_W  = 4;
  localparam int WORD_W = 48;

  // Link word toward the next layer; field order is decoded downstream.
  typedef struct packed {
    logic [SUM_W-1:0] sum;
    logic [IDX_W-1:0] idx;
    logic [Q_W-1:0]   maxq;
    logic [T_W-1:0]   tmin;
    logic             hit;
    logic [2:0]       spare;
  } link_word_t;
endpackage

// File: rtl/pmt_sum_chan.sv
module pmt_sum_chan #(
  parameter int SAMP_W    = 10,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 6,
  parameter int Q_W       = 12,
  parameter int T_W       = 12
) (
  input  logic              clk,
  input  logic              en,
  input  logic [SAMP_W-1:0] sample,
  input  logic [GAIN_W-1:0] gain,
  input  logic [Q_W-1:0]    ped,
  input  logic              hit,
  input  logic [T_W-1:0]    t_in,
  output logic [Q_W-1:0]    q_o,
  output logic [T_W-1:0]    t_o
);
  localparam int PROD_W = SAMP_W + GAIN_W;
  localparam int SC_W   = PROD_W - GAIN_FRAC;
  localparam int DW     = ((SC_W > Q_W) ? SC_W : Q_W) + 1;

  logic [PROD_W-1:0] prod_q;
  logic              hit_q;
  logic [T_W-1:0]    t_q;
  logic [SC_W-1:0]   scaled;
  logic [DW-1:0]     a_w, b_w, diff;
  logic [Q_W-1:0]    q_next;

  // Stage: gain multiply
  always_ff @(posedge clk) begin
    if (en) begin
      prod_q <= PROD_W'(sample) * PROD_W'(gain);
      hit_q  <= hit;
      t_q    <= t_in;
    end
  end

  // Stage: drop fraction, subtract pedestal, clamp low and high
  always_comb begin
    scaled = prod_q[PROD_W-1:GAIN_FRAC];
    a_w    = DW'(scaled);
    b_w    = DW'(ped);
    diff   = a_w - b_w;
    if (a_w <= b_w)
      q_next = '0;
    else if (diff > DW'({Q_W{1'b1}}))
      q_next = '1;
    else
      q_next = diff[Q_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (en) begin
      q_o <= q_next;
      t_o <= hit_q ? t_q : '1;
    end
  end
endmodule

// File: rtl/pmt_sum_reduce.sv
module pmt_sum_reduce #(
  parameter int N_IN     = 4,
  parameter int SUM_IN_W = 12,
  parameter int SUM_W    = 16,
  parameter int Q_W      = 12,
  parameter int T_W      = 12,
  parameter int IDX_W    = 4
) (
  input  logic [N_IN*SUM_IN_W-1:0] sum_i,
  input  logic [N_IN*Q_W-1:0]      q_i,
  input  logic [N_IN*IDX_W-1:0]    idx_i,
  input  logic [N_IN*T_W-1:0]      t_i,
  input  logic [N_IN-1:0]          hv_i,
  output logic [SUM_W-1:0]         sum_o,
  output logic [Q_W-1:0]           q_o,
  output logic [IDX_W-1:0]         idx_o,
  output logic [T_W-1:0]           t_o,
  output logic                     hv_o
);
  // Items are ordered by channel index; strict compare keeps the earliest on ties.
  always_comb begin
    sum_o = '0;
    q_o   = q_i[Q_W-1:0];
    idx_o = idx_i[IDX_W-1:0];
    t_o   = t_i[T_W-1:0];
    hv_o  = |hv_i;
    for (int k = 0; k < N_IN; k++) begin
      sum_o = sum_o + SUM_W'(sum_i[k*SUM_IN_W +: SUM_IN_W]);
      if (q_i[k*Q_W +: Q_W] > q_o) begin
        q_o   = q_i[k*Q_W +: Q_W];
        idx_o = idx_i[k*IDX_W +: IDX_W];
      end
      if (t_i[k*T_W +: T_W] < t_o)
        t_o = t_i[k*T_W +: T_W];
    end
  end
endmodule

// File: rtl/pmt_sum_wavebuf.sv
module pmt_sum_wavebuf #(
  parameter int N_CH   = 16,
  parameter int SAMP_W = 10,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [N_CH*SAMP_W-1:0]   wr_data,
  input  logic [$clog2(N_CH)-1:0]  rd_ch,
  input  logic [$clog2(DEPTH)-1:0] rd_age,
  output logic [SAMP_W-1:0]        rd_data
);
  localparam int AGE_W = $clog2(DEPTH);

  logic [N_CH*SAMP_W-1:0] mem [DEPTH];
  logic [AGE_W-1:0]       wptr;
  logic [AGE_W-1:0]       raddr;
  logic [N_CH*SAMP_W-1:0] rrow;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wptr <= '0;
    else if (wr_en) wptr <= wptr + AGE_W'(1);
  end

  always_comb begin
    raddr = wptr - AGE_W'(1) - rd_age;
    rrow  = mem[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rrow[rd_ch*SAMP_W +: SAMP_W];
  end
endmodule

// File: rtl/pmt_sum_front.sv
module pmt_sum_front
  import pmt_sum_pkg::*;
#(
  parameter int N_CH      = 16,
  parameter int SAMP_W    = 10,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 6,
  parameter int DEPTH     = 16,
  parameter int GRP       = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [N_CH*SAMP_W-1:0]     in_samples,
  input  logic [N_CH-1:0]            in_hits,
  input  logic [N_CH*T_W-1:0]        in_times,
  input  logic [N_CH*GAIN_W-1:0]     gain_cfg,
  input  logic [N_CH*Q_W-1:0]        ped_cfg,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [WORD_W-1:0]          out_word,
  input  logic [$clog2(N_CH)-1:0]    rd_ch,
  input  logic [$clog2(DEPTH)-1:0]   rd_age,
  output logic [SAMP_W-1:0]          rd_data
);
  localparam int NG     = N_CH / GRP;
  localparam int NSTAGE = 6;

  logic [NSTAGE-1:0] vld;
  logic              en;
  logic              accept;

  assign en       = !vld[NSTAGE-1] || out_ready;
  assign in_ready = en;
  assign accept   = in_valid && en;
  assign out_valid = vld[NSTAGE-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (en) vld <= {vld[NSTAGE-2:0], in_valid};
  end

  // Stage 1: capture
  logic [N_CH*SAMP_W-1:0] s1_samp;
  logic [N_CH-1:0]        s1_hit;
  logic [N_CH*T_W-1:0]    s1_time;

  always_ff @(posedge clk) begin
    if (en) begin
      s1_samp <= in_samples;
      s1_hit  <= in_hits;
      s1_time <= in_times;
    end
  end

  // Stages 2-3: per-channel conditioning
  logic [N_CH*Q_W-1:0] ch_q;
  logic [N_CH*T_W-1:0] ch_t;
  logic [N_CH-1:0]     ch_hv;

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    pmt_sum_chan #(
      .SAMP_W(SAMP_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC),
      .Q_W(Q_W), .T_W(T_W)
    ) u_chan (
      .clk    (clk),
      .en     (en),
      .sample (s1_samp[c*SAMP_W +: SAMP_W]),
      .gain   (gain_cfg[c*GAIN_W +: GAIN_W]),
      .ped    (ped_cfg[c*Q_W +: Q_W]),
      .hit    (s1_hit[c]),
      .t_in   (s1_time[c*T_W +: T_W]),
      .q_o    (ch_q[c*Q_W +: Q_W]),
      .t_o    (ch_t[c*T_W +: T_W])
    );
  end

  // Hit flags follow the two conditioning stages
  logic [N_CH-1:0] hv_d2;
  always_ff @(posedge clk) begin
    if (en) begin
      hv_d2 <= s1_hit;
      ch_hv <= hv_d2;
    end
  end

  // Stage 4: reduce within groups
  logic [NG*SUM_W-1:0] g_sum_r;
  logic [NG*Q_W-1:0]   g_q_r;
  logic [NG*IDX_W-1:0] g_idx_r;
  logic [NG*T_W-1:0]   g_t_r;
  logic [NG-1:0]       g_hv_r;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [GRP*IDX_W-1:0] idx_c;
    logic [SUM_W-1:0]     sum_w;
    logic [Q_W-1:0]       q_w;
    logic [IDX_W-1:0]     idx_w;
    logic [T_W-1:0]       t_w;
    logic                 hv_w;

    for (genvar j = 0; j < GRP; j++) begin : g_idx
      assign idx_c[j*IDX_W +: IDX_W] = IDX_W'(g*GRP + j);
    end

    pmt_sum_reduce #(
      .N_IN(GRP), .SUM_IN_W(Q_W), .SUM_W(SUM_W),
      .Q_W(Q_W), .T_W(T_W), .IDX_W(IDX_W)
    ) u_red (
      .sum_i (ch_q[g*GRP*Q_W +: GRP*Q_W]),
      .q_i   (ch_q[g*GRP*Q_W +: GRP*Q_W]),
      .idx_i (idx_c),
      .t_i   (ch_t[g*GRP*T_W +: GRP*T_W]),
      .hv_i  (ch_hv[g*GRP +: GRP]),
      .sum_o (sum_w),
      .q_o   (q_w),
      .idx_o (idx_w),
      .t_o   (t_w),
      .hv_o  (hv_w)
    );

    always_ff @(posedge clk) begin
      if (en) begin
        g_sum_r[g*SUM_W +: SUM_W] <= sum_w;
        g_q_r[g*Q_W +: Q_W]       <= q_w;
        g_idx_r[g*IDX_W +: IDX_W] <= idx_w;
        g_t_r[g*T_W +: T_W]       <= t_w;
        g_hv_r[g]                 <= hv_w;
      end
    end
  end

  // Stage 5: reduce across groups
  logic [SUM_W-1:0] f_sum_w, f_sum_r;
  logic [Q_W-1:0]   f_q_w, f_q_r;
  logic [IDX_W-1:0] f_idx_w, f_idx_r;
  logic [T_W-1:0]   f_t_w, f_t_r;
  logic             f_hv_w, f_hv_r;

  pmt_sum_reduce #(
    .N_IN(NG), .SUM_IN_W(SUM_W), .SUM_W(SUM_W),
    .Q_W(Q_W), .T_W(T_W), .IDX_W(IDX_W)
  ) u_red_top (
    .sum_i (g_sum_r),
    .q_i   (g_q_r),
    .idx_i (g_idx_r),
    .t_i   (g_t_r),
    .hv_i  (g_hv_r),
    .sum_o (f_sum_w),
    .q_o   (f_q_w),
    .idx_o (f_idx_w),
    .t_o   (f_t_w),
    .hv_o  (f_hv_w)
  );

  always_ff @(posedge clk) begin
    if (en) begin
      f_sum_r <= f_sum_w;
      f_q_r   <= f_q_w;
      f_idx_r <= f_idx_w;
      f_t_r   <= f_t_w;
      f_hv_r  <= f_hv_w;
    end
  end

  // Stage 6: pack link word
  link_word_t word_r;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_r <= '0;
    else if (en) begin
      word_r.sum   <= f_sum_r;
      word_r.idx   <= f_idx_r;
      word_r.maxq  <= f_q_r;
      word_r.tmin  <= f_t_r;
      word_r.hit   <= f_hv_r;
      word_r.spare <= '0;
    end
  end
  assign out_word = word_r;

  // Raw waveform history
  pmt_sum_wavebuf #(
    .N_CH(N_CH), .SAMP_W(SAMP_W), .DEPTH(DEPTH)
  ) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept),
    .wr_data (in_samples),
    .rd_ch   (rd_ch),
    .rd_age  (rd_age),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/pmt_sum_front_chk.sv
module pmt_sum_front_chk
  import pmt_sum_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word
);
  link_word_t w;
  assign w = out_word;

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  p_backpressure_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_max_le_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> SUM_W'(w.maxq) <= w.sum);

  p_zero_tie_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && w.sum == '0 |-> w.idx == '0 && w.maxq == '0);

  p_nohit_time_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !w.hit |-> w.tmin == '1);
endmodule

bind pmt_sum_front pmt_sum_front_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word)
);

// File: tb/pmt_sum_front_bench.sv
`timescale 1ns/1ps
module pmt_sum_front_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [159:0] in_samples = '0;
  logic [15:0]  in_hits = '0;
  logic [191:0] in_times = '0;
  logic [127:0] gain_cfg = '0;
  logic [191:0] ped_cfg = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [47:0]  out_word;
  logic [3:0]   rd_ch = '0;
  logic [3:0]   rd_age = '0;
  logic [9:0]   rd_data;

  int checks = 0;
  int errors = 0;
  int sent = 0;
  int recvd = 0;
  bit stall_en = 1'b0;
  logic [47:0]  exp_q[$];
  logic [159:0] hist[$];
  int sv[16];
  int tv[16];

  always #2 clk = ~clk;

  pmt_sum_front u_pmt_sum_front (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_samples(in_samples), .in_hits(in_hits), .in_times(in_times),
    .gain_cfg(gain_cfg), .ped_cfg(ped_cfg), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .rd_ch(rd_ch),
    .rd_age(rd_age), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] model(input logic [159:0] s, input logic [15:0] h, input logic [191:0] t);
    int sum = 0, mq = 0, mi = 0, mt = 4095, hv = 0;
    for (int c = 0; c < 16; c++) begin
      int p = int'(s[c*10 +: 10]) * int'(gain_cfg[c*8 +: 8]);
      int sc = p / 64;
      int pd = int'(ped_cfg[c*12 +: 12]);
      int q = (sc > pd) ? sc - pd : 0;
      if (q > 4095) q = 4095;
      sum += q;
      if (q > mq) begin mq = q; mi = c; end
      if (h[c]) begin
        hv = 1;
        if (int'(t[c*12 +: 12]) < mt) mt = int'(t[c*12 +: 12]);
      end
    end
    return {sum[15:0], mi[3:0], mq[11:0], mt[11:0], hv[0], 3'b000};
  endfunction

  task automatic send(input logic [159:0] s, input logic [15:0] h, input logic [191:0] t);
    bit ok;
    exp_q.push_back(model(s, h, t));
    in_samples = s; in_hits = h; in_times = t; in_valid = 1'b1;
    forever begin
      ok = in_ready;
      @(negedge clk);
      if (ok) break;
    end
    in_valid = 1'b0;
    hist.push_back(s);
    sent++;
  endtask

  task automatic send_arr(input logic [15:0] h);
    logic [159:0] s;
    logic [191:0] t;
    for (int c = 0; c < 16; c++) begin
      s[c*10 +: 10] = sv[c][9:0];
      t[c*12 +: 12] = tv[c][11:0];
    end
    send(s, h, t);
  endtask

  task automatic set_cfg(input int g, input int p);
    for (int c = 0; c < 16; c++) begin
      gain_cfg[c*8 +: 8]   = g[7:0];
      ped_cfg[c*12 +: 12]  = p[11:0];
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // Output ready: changes just after a rising edge
  initial forever begin
    @(posedge clk);
    #1 out_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
  end

  // Scoreboard monitor
  initial begin
    logic [47:0] held;
    logic [47:0] e;
    bit held_v;
    held_v = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (held_v) chk(out_word == held, "R1 held word", out_word, held);
        held_v = 1'b0;
        if (out_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R10 unexpected word", out_word, 48'h0);
          end else begin
            e = exp_q.pop_front();
            recvd++;
            chk(out_word[47:32] == e[47:32], "R4 sum", out_word, e);
            chk(out_word[31:16] == e[31:16], "R5 max index/charge", out_word, e);
            chk(out_word[15:3]  == e[15:3],  "R6 min time/hit", out_word, e);
            chk(out_word[2:0]   == e[2:0],   "R7 spare", out_word, e);
          end
        end else begin
          held = out_word; held_v = 1'b1;
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog expired", 48'h0, 48'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    set_cfg(64, 0);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid in reset", {47'h0, out_valid}, 48'h0);
    chk(in_ready == 1'b1, "R8 in_ready in reset", {47'h0, in_ready}, 48'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R8 idle after reset", {46'h0, out_valid, in_ready}, 48'h1);

    // R2 latency
    for (int c = 0; c < 16; c++) begin sv[c] = 10 * c; tv[c] = 100 + c; end
    send_arr(16'h0020);
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R2 not early", {47'h0, out_valid}, 48'h0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R2 sixth edge", {47'h0, out_valid}, 48'h1);
    drain();

    // R5 all zero -> index 0, R6 no hit
    for (int c = 0; c < 16; c++) begin sv[c] = 0; tv[c] = 5; end
    send_arr(16'h0000);
    // R5 uniform tie
    for (int c = 0; c < 16; c++) sv[c] = 500;
    send_arr(16'h0000);
    // R5 ramp, max at channel 15
    for (int c = 0; c < 16; c++) sv[c] = 30 + 60 * c;
    send_arr(16'h0000);
    // R5 equal peaks at 3 and 9
    for (int c = 0; c < 16; c++) sv[c] = 20;
    sv[3] = 900; sv[9] = 900;
    send_arr(16'h0000);
    // R6 min over hits only; channel 0 has smallest time but no hit
    for (int c = 0; c < 16; c++) begin sv[c] = 40; tv[c] = 1000 - c; end
    tv[0] = 1; tv[12] = 77; tv[4] = 80;
    send_arr(16'b0001_0000_0001_0000);
    // R6 hit at time 0xFFF
    for (int c = 0; c < 16; c++) tv[c] = 4095;
    send_arr(16'h8000);
    drain();

    // R3 pedestal clamp
    set_cfg(64, 300);
    for (int c = 0; c < 16; c++) sv[c] = 250 + 10 * c;
    send_arr(16'h0000);
    drain();
    // R3 full scale
    set_cfg(255, 0);
    for (int c = 0; c < 16; c++) sv[c] = 1023;
    send_arr(16'h0001);
    drain();
    // R3 gain zero
    set_cfg(0, 0);
    send_arr(16'h0000);
    drain();
    // R3 half gain truncation
    set_cfg(32, 1);
    for (int c = 0; c < 16; c++) sv[c] = 2 * c + 1;
    send_arr(16'h0000);
    drain();

    // R10 random traffic with random stalls
    for (int c = 0; c < 16; c++) begin
      gain_cfg[c*8 +: 8]  = 8'($urandom);
      ped_cfg[c*12 +: 12] = 12'($urandom % 600);
    end
    stall_en = 1'b1;
    for (int n = 0; n < 80; n++) begin
      logic [159:0] s;
      logic [191:0] t;
      for (int c = 0; c < 16; c++) begin
        s[c*10 +: 10] = 10'($urandom);
        t[c*12 +: 12] = 12'($urandom);
      end
      send(s, 16'($urandom) & 16'($urandom), t);
    end
    drain();
    stall_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(recvd == sent, "R10 word count", 48'(recvd), 48'(sent));

    // R9 history reads
    for (int k = 0; k < 10; k++) begin
      int age = (k == 0) ? 15 : ((k == 1) ? 0 : int'($urandom % 16));
      int ch  = (k == 0) ? 15 : int'($urandom % 16);
      logic [159:0] row;
      rd_ch = 4'(ch); rd_age = 4'(age);
      @(negedge clk);
      row = hist[hist.size() - 1 - age];
      chk(rd_data == row[ch*10 +: 10], "R9 history read", 48'(rd_data), 48'(row[ch*10 +: 10]));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule